// File: doc/BRIEF.md
# Binary/Decimal Accumulator ALU

This unit is the arithmetic and logic core of a small accumulator-based processor. Each operation takes a 4-bit operation code, a register operand (the accumulator or an index register, whichever the caller routes in) and a memory operand. It also takes the current status byte. From these it produces a result byte and an updated status byte. It covers add with carry, subtract with borrow, compare, the three bitwise logic operations, bit test, increment, decrement, load, and the four shift and rotate forms.

Add and subtract follow the decimal flag of the incoming status byte. When that flag is clear they work on plain binary bytes. When it is set they treat both operands as two packed BCD digits and return a packed BCD result. Only the flags an operation is defined to affect are rewritten. Every other status bit comes through unchanged.

The datapath is combinational. The parameter `REG_OUT` selects a registered output stage: 1 (the default) registers the result and status, and 0 passes them straight through. Operand fetch, the register file and instruction decoding lie outside the unit.

Top module: `acc_alu`

## Requirements
- R1: With `REG_OUT`=1, `res_o` and `stat_o` are 0x00 while `rst_n` is low. After reset, the result of the inputs present at a rising clock edge appears on the outputs from that edge on, which is one cycle of latency.
- R2: Status bits are N=bit7, V=bit6, D=bit3, Z=bit1, C=bit0. Operation codes are ADC=0, SBC=1, CMP=2, AND=3, ORA=4, EOR=5, BIT=6, INC=7, DEC=8, ASL=9, LSR=10, ROL=11, ROR=12, LOAD=13. Codes 14 and 15 pass `reg_i` to the result and leave the status byte as it came in.
- R3: Binary ADC (D=0) gives result = (reg + mem + C) mod 256. C is set when the unsigned sum exceeds 0xFF. V is set when the signed sum leaves -128..127. N is result bit7 and Z is set when the result is zero.
- R4: Binary SBC (D=0) uses borrow = NOT C and gives result = (reg - mem - borrow) mod 256. C is set when no borrow occurs (reg >= mem + borrow). V is set when the signed difference leaves -128..127. N and Z follow the result.
- R5: Decimal ADC (D=1) reads each operand as tens digit in bits 7:4 and units digit in bits 3:0, and adds them with C. C is set when the decimal sum exceeds 99. The result is the sum modulo 100, written back in packed BCD. N and Z come from the packed result. V comes from the binary signed rule applied to the raw bytes.
- R6: Decimal SBC (D=1) subtracts the decimal values and the borrow. C is set when the decimal difference is not negative. A negative difference wraps by adding 100. The result is packed BCD. N, Z and V follow the same rules as in R5.
- R7: CMP sets C when mem <= reg, and takes N and Z from (reg - mem) mod 256. The result equals `reg_i`, and V is left unchanged.
- R8: BIT sets Z when (reg AND mem) is zero, copies mem bit7 into N and mem bit6 into V, and returns `reg_i` unchanged as the result.
- R9: AND, ORA, EOR and LOAD (result = mem) update only N and Z from their result.
- R10: INC and DEC act on `reg_i` modulo 256 and update only N and Z.
- R11: ASL and ROL move reg bit7 into C. LSR and ROR move reg bit0 into C. ASL and LSR fill the vacated bit with 0, while ROL and ROR fill it with the old C. N and Z follow the result.
- R12: Status bits 5..2, and every flag an operation does not list, come through unchanged from `stat_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_i | input | 4 | Operation code |
| reg_i | input | 8 | Register operand (accumulator or index) |
| mem_i | input | 8 | Memory operand |
| stat_i | input | 8 | Incoming status byte |
| res_o | output | 8 | Result byte |
| stat_o | output | 8 | Updated status byte |

## Verification
The bench exercises the default configuration, where the result byte and the status byte share one register stage. Both are therefore due at the first rising edge after the operands are applied. The bench applies each operand set at a falling edge and compares both outputs at the next falling edge, half a period after the capturing edge and clear of it. The embedded properties use the same one-edge spacing: they relate the outputs at an edge to the inputs sampled at the edge before.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;
    localparam int DEC_MOD = 100;

    localparam int FL_N = 7;
    localparam int FL_V = 6;
    localparam int FL_D = 3;
    localparam int FL_Z = 1;
    localparam int FL_C = 0;

    typedef enum logic [3:0] {
        OP_ADC  = 4'd0,
        OP_SBC  = 4'd1,
        OP_CMP  = 4'd2,
        OP_AND  = 4'd3,
        OP_ORA  = 4'd4,
        OP_EOR  = 4'd5,
        OP_BIT  = 4'd6,
        OP_INC  = 4'd7,
        OP_DEC  = 4'd8,
        OP_ASL  = 4'd9,
        OP_LSR  = 4'd10,
        OP_ROL  = 4'd11,
        OP_ROR  = 4'd12,
        OP_LOAD = 4'd13,
        OP_PASS = 4'd14,
        OP_PSX  = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic [BYTE_W-1:0] res;
        logic [BYTE_W-1:0] stat;
    } alu_out_t;

    // Value of a packed two-digit decimal byte.
    function automatic int bcd_value(input logic [BYTE_W-1:0] v);
        return int'(v[BYTE_W-1:NIB_W]) * 10 + int'(v[NIB_W-1:0]);
    endfunction

    // Pack a value in 0..99 back into two decimal digits.
    function automatic logic [BYTE_W-1:0] bcd_pack(input int v);
        return {NIB_W'(v / 10), NIB_W'(v % 10)};
    endfunction

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder
    import acc_alu_pkg::*;
(
    input  logic [BYTE_W-1:0] a_i,
    input  logic [BYTE_W-1:0] b_i,
    input  logic              carry_i,
    input  logic              sub_i,
    input  logic              dec_i,
    output logic [BYTE_W-1:0] sum_o,
    output logic              carry_o,
    output logic              ovf_o
);

    logic [BYTE_W-1:0] b_eff;
    logic [BYTE_W:0]   bin_sum;
    logic [BYTE_W-1:0] dec_sum;
    logic              dec_carry;

    // Binary path: subtraction is addition of the complement with the
    // carry flag acting as the inverted borrow.
    always_comb begin
        b_eff   = sub_i ? ~b_i : b_i;
        bin_sum = {1'b0, a_i} + {1'b0, b_eff} + {{BYTE_W{1'b0}}, carry_i};
    end

    // Decimal path on the integer values of both digit pairs.
    always_comb begin
        int a_val;
        int b_val;
        int t;
        a_val = bcd_value(a_i);
        b_val = bcd_value(b_i);
        if (sub_i) begin
            t = a_val - b_val - (carry_i ? 0 : 1);
            if (t < 0) begin
                dec_carry = 1'b0;
                t = t + DEC_MOD;
            end else begin
                dec_carry = 1'b1;
            end
        end else begin
            t = a_val + b_val + (carry_i ? 1 : 0);
            if (t >= DEC_MOD) begin
                dec_carry = 1'b1;
                t = t - DEC_MOD;
            end else begin
                dec_carry = 1'b0;
            end
        end
        dec_sum = bcd_pack(t);
    end

    always_comb begin
        sum_o   = dec_i ? dec_sum : bin_sum[BYTE_W-1:0];
        carry_o = dec_i ? dec_carry : bin_sum[BYTE_W];
        ovf_o   = (a_i[BYTE_W-1] == b_eff[BYTE_W-1]) &&
                  (bin_sum[BYTE_W-1] != a_i[BYTE_W-1]);
    end

endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
    import acc_alu_pkg::*;
(
    input  alu_op_e           op_i,
    input  logic [BYTE_W-1:0] a_i,
    input  logic [BYTE_W-1:0] m_i,
    input  logic              carry_i,
    output logic [BYTE_W-1:0] res_o,
    output logic              carry_o
);

    always_comb begin
        res_o   = a_i;
        carry_o = carry_i;
        case (op_i)
            OP_AND:  res_o = a_i & m_i;
            OP_ORA:  res_o = a_i | m_i;
            OP_EOR:  res_o = a_i ^ m_i;
            OP_INC:  res_o = a_i + {{(BYTE_W-1){1'b0}}, 1'b1};
            OP_DEC:  res_o = a_i - {{(BYTE_W-1){1'b0}}, 1'b1};
            OP_LOAD: res_o = m_i;
            OP_ASL: begin
                res_o   = {a_i[BYTE_W-2:0], 1'b0};
                carry_o = a_i[BYTE_W-1];
            end
            OP_LSR: begin
                res_o   = {1'b0, a_i[BYTE_W-1:1]};
                carry_o = a_i[0];
            end
            OP_ROL: begin
                res_o   = {a_i[BYTE_W-2:0], carry_i};
                carry_o = a_i[BYTE_W-1];
            end
            OP_ROR: begin
                res_o   = {carry_i, a_i[BYTE_W-1:1]};
                carry_o = a_i[0];
            end
            default: begin
                res_o   = a_i;
                carry_o = carry_i;
            end
        endcase
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] op_i,
    input  logic [7:0] reg_i,
    input  logic [7:0] mem_i,
    input  logic [7:0] stat_i,
    output logic [7:0] res_o,
    output logic [7:0] stat_o
);

    alu_op_e           op;
    logic [BYTE_W-1:0] add_sum;
    logic              add_carry;
    logic              add_ovf;
    logic [BYTE_W-1:0] bit_res;
    logic              bit_carry;
    logic [BYTE_W-1:0] cmp_diff;
    alu_out_t          out_d;

    assign op = alu_op_e'(op_i);

    acc_alu_adder u_adder (
        .a_i     (reg_i),
        .b_i     (mem_i),
        .carry_i (stat_i[FL_C]),
        .sub_i   (op == OP_SBC),
        .dec_i   (stat_i[FL_D]),
        .sum_o   (add_sum),
        .carry_o (add_carry),
        .ovf_o   (add_ovf)
    );

    acc_alu_bitops u_bitops (
        .op_i    (op),
        .a_i     (reg_i),
        .m_i     (mem_i),
        .carry_i (stat_i[FL_C]),
        .res_o   (bit_res),
        .carry_o (bit_carry)
    );

    assign cmp_diff = reg_i - mem_i;

    always_comb begin
        out_d.res  = reg_i;
        out_d.stat = stat_i;
        case (op)
            OP_ADC, OP_SBC: begin
                out_d.res        = add_sum;
                out_d.stat[FL_C] = add_carry;
                out_d.stat[FL_V] = add_ovf;
                out_d.stat[FL_N] = add_sum[BYTE_W-1];
                out_d.stat[FL_Z] = (add_sum == '0);
            end
            OP_CMP: begin
                out_d.stat[FL_C] = (mem_i <= reg_i);
                out_d.stat[FL_N] = cmp_diff[BYTE_W-1];
                out_d.stat[FL_Z] = (cmp_diff == '0);
            end
            OP_BIT: begin
                out_d.stat[FL_Z] = ((reg_i & mem_i) == '0);
                out_d.stat[FL_N] = mem_i[BYTE_W-1];
                out_d.stat[FL_V] = mem_i[BYTE_W-2];
            end
            OP_AND, OP_ORA, OP_EOR, OP_INC, OP_DEC, OP_LOAD: begin
                out_d.res        = bit_res;
                out_d.stat[FL_N] = bit_res[BYTE_W-1];
                out_d.stat[FL_Z] = (bit_res == '0);
            end
            OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
                out_d.res        = bit_res;
                out_d.stat[FL_C] = bit_carry;
                out_d.stat[FL_N] = bit_res[BYTE_W-1];
                out_d.stat[FL_Z] = (bit_res == '0);
            end
            default: begin
                out_d.res  = reg_i;
                out_d.stat = stat_i;
            end
        endcase
    end

    generate
        if (REG_OUT) begin : g_reg
            alu_out_t out_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    out_q <= '0;
                end else begin
                    out_q <= out_d;
                end
            end

            assign res_o  = out_q.res;
            assign stat_o = out_q.stat;

            AST_CMP_KEEPS_REG: assert property (@(posedge clk) disable iff (!rst_n)
                (op_i == OP_CMP) |=> (res_o == $past(reg_i)) &&
                                     (stat_o[FL_V] == $past(stat_i[FL_V]))); // R7

            AST_BIT_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
                (op_i == OP_BIT) |=> (stat_o[FL_N] == $past(mem_i[7])) &&
                                     (stat_o[FL_V] == $past(mem_i[6])) &&
                                     (res_o == $past(reg_i))); // R8

            AST_UPPER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
                (op_i != OP_ADC) |=> (stat_o[5:2] == $past(stat_i[5:2]))); // R12

            AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
                ((op_i == OP_AND) || (op_i == OP_ORA) || (op_i == OP_EOR) ||
                 (op_i == OP_INC) || (op_i == OP_DEC) || (op_i == OP_LOAD))
                |=> (stat_o[FL_Z] == (res_o == 8'h00)) &&
                    (stat_o[FL_C] == $past(stat_i[FL_C]))); // R9

            AST_LEFT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
                ((op_i == OP_ASL) || (op_i == OP_ROL))
                |=> (stat_o[FL_C] == $past(reg_i[7])) &&
                    (res_o[7:1] == $past(reg_i[6:0]))); // R11

            AST_DEC_ADD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
                ((op_i == OP_ADC) && stat_i[FL_D] &&
                 (reg_i[7:4] < 4'd10) && (reg_i[3:0] < 4'd10) &&
                 (mem_i[7:4] < 4'd10) && (mem_i[3:0] < 4'd10))
                |=> (res_o[7:4] < 4'd10) && (res_o[3:0] < 4'd10)); // R5
        end else begin : g_comb
            assign res_o  = out_d.res;
            assign stat_o = out_d.stat;
        end
    endgenerate

endmodule

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;

    localparam time CLK_PERIOD = 10ns;

    logic       clk;
    logic       rst_n;
    logic [3:0] op_i;
    logic [7:0] reg_i;
    logic [7:0] mem_i;
    logic [7:0] stat_i;
    logic [7:0] res_o;
    logic [7:0] stat_o;

    int  n_checks;
    int  n_errors;
    bit  finished;

    acc_alu dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (op_i),
        .reg_i  (reg_i),
        .mem_i  (mem_i),
        .stat_i (stat_i),
        .res_o  (res_o),
        .stat_o (stat_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check8(input string tag, input string what,
                          input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    // Apply at a falling edge, capture at the next rising edge,
    // compare at the following falling edge.
    task automatic run_op(input string tag, input logic [3:0] op,
                          input logic [7:0] r, input logic [7:0] m,
                          input logic [7:0] s, input logic [7:0] exp_res,
                          input logic [7:0] exp_stat);
        @(negedge clk);
        op_i = op; reg_i = r; mem_i = m; stat_i = s;
        @(negedge clk);
        check8(tag, "result", res_o, exp_res);
        check8(tag, "status", stat_o, exp_stat);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        op_i = 4'd0; reg_i = 8'h33; mem_i = 8'h44; stat_i = 8'hFF;
        repeat (3) @(negedge clk);
        check8("R1", "reset result", res_o, 8'h00);
        check8("R1", "reset status", stat_o, 8'h00);
        rst_n = 1'b1;
        // First capture after release: one cycle latency
        run_op("R1", 4'd0, 8'h01, 8'h02, 8'h20, 8'h03, 8'h20);
    endtask

    task automatic t_bin_add;
        run_op("R3", 4'd0, 8'h50, 8'h50, 8'h20, 8'hA0, 8'hE0);
        run_op("R3", 4'd0, 8'hFF, 8'h01, 8'h20, 8'h00, 8'h23);
        run_op("R3", 4'd0, 8'h7F, 8'h00, 8'h21, 8'h80, 8'hE0);
        run_op("R3", 4'd0, 8'h01, 8'h01, 8'h60, 8'h02, 8'h20);
    endtask

    task automatic t_bin_sub;
        run_op("R4", 4'd1, 8'h50, 8'hF0, 8'h21, 8'h60, 8'h20);
        run_op("R4", 4'd1, 8'h10, 8'h0F, 8'h20, 8'h00, 8'h23);
        run_op("R4", 4'd1, 8'h80, 8'h01, 8'h21, 8'h7F, 8'h61);
    endtask

    task automatic t_dec_add;
        run_op("R5", 4'd0, 8'h45, 8'h38, 8'h28, 8'h83, 8'hA8);
        run_op("R5", 4'd0, 8'h58, 8'h46, 8'h29, 8'h05, 8'h69);
        run_op("R5", 4'd0, 8'h99, 8'h01, 8'h28, 8'h00, 8'h2B);
    endtask

    task automatic t_dec_sub;
        run_op("R6", 4'd1, 8'h42, 8'h13, 8'h29, 8'h29, 8'h29);
        run_op("R6", 4'd1, 8'h12, 8'h21, 8'h29, 8'h91, 8'hA8);
        run_op("R6", 4'd1, 8'h00, 8'h00, 8'h28, 8'h99, 8'hA8);
    endtask

    task automatic t_compare;
        run_op("R7", 4'd2, 8'h40, 8'h40, 8'h60, 8'h40, 8'h63);
        run_op("R7", 4'd2, 8'h10, 8'h20, 8'h21, 8'h10, 8'hA0);
        run_op("R7", 4'd2, 8'h20, 8'h10, 8'h20, 8'h20, 8'h21);
    endtask

    task automatic t_bit_test;
        run_op("R8", 4'd6, 8'h0F, 8'hC0, 8'h21, 8'h0F, 8'hE3);
        run_op("R8", 4'd6, 8'hFF, 8'h01, 8'hE2, 8'hFF, 8'h20);
    endtask

    task automatic t_logic;
        run_op("R9", 4'd3, 8'hF0, 8'h0F, 8'h61, 8'h00, 8'h63);
        run_op("R9", 4'd4, 8'h80, 8'h01, 8'h22, 8'h81, 8'hA0);
        run_op("R9", 4'd5, 8'hFF, 8'hFF, 8'h20, 8'h00, 8'h22);
        run_op("R9", 4'd13, 8'h12, 8'h80, 8'h43, 8'h80, 8'hC1);
    endtask

    task automatic t_incdec;
        run_op("R10", 4'd7, 8'hFF, 8'h00, 8'h41, 8'h00, 8'h43);
        run_op("R10", 4'd8, 8'h00, 8'h00, 8'h20, 8'hFF, 8'hA0);
        run_op("R10", 4'd8, 8'h01, 8'h00, 8'h20, 8'h00, 8'h22);
    endtask

    task automatic t_shift;
        run_op("R11", 4'd9,  8'h81, 8'h00, 8'h21, 8'h02, 8'h21);
        run_op("R11", 4'd9,  8'h40, 8'h00, 8'h21, 8'h80, 8'hA0);
        run_op("R11", 4'd10, 8'h01, 8'h00, 8'h20, 8'h00, 8'h23);
        run_op("R11", 4'd11, 8'h80, 8'h00, 8'h21, 8'h01, 8'h21);
        run_op("R11", 4'd11, 8'h80, 8'h00, 8'h20, 8'h00, 8'h23);
        run_op("R11", 4'd12, 8'h01, 8'h00, 8'h21, 8'h80, 8'hA1);
        run_op("R11", 4'd12, 8'h02, 8'h00, 8'h20, 8'h01, 8'h20);
    endtask

    task automatic t_passthrough;
        run_op("R2", 4'd14, 8'h5A, 8'h11, 8'hFF, 8'h5A, 8'hFF);
        run_op("R2", 4'd15, 8'hA5, 8'h22, 8'h00, 8'hA5, 8'h00);
        run_op("R12", 4'd0, 8'h01, 8'h01, 8'h24, 8'h02, 8'h24);
        run_op("R12", 4'd3, 8'hFF, 8'h0F, 8'hFC, 8'h0F, 8'h7C);
    endtask

    initial begin
        n_checks = 0;
        n_errors = 0;
        finished = 1'b0;
        t_reset();
        t_bin_add();
        t_bin_sub();
        t_dec_add();
        t_dec_sub();
        t_compare();
        t_bit_test();
        t_logic();
        t_incdec();
        t_shift();
        t_passthrough();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog R1: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule